// File: doc/BRIEF.md
# Nested Trap Level State Stack

This block keeps the processor state that must survive a trap, one stack slot per nested trap level. When a trap is requested with a 9-bit trap type, it packs the condition codes, address-space identifier, processor-state field and window pointer into one saved word. It stores that word, the current PC, the next-PC and the trap type in the slot selected by the present trap level. In the same step it computes the state the processor continues with: privileged processor state, a window pointer adjusted for window traps, and a vector address built from the trap base and the trap type. It then raises the trap level, or saturates it and flags the red (error-recovery) state when the stack is nearly full.

Two return operations unwind one level. A done return resumes after the trapping instruction, and a retry return re-executes it. Both unpack the saved word of the level being left. The register file, the fetch unit and the trap base register stay outside the block. It takes their present values on inputs and drives the resulting PC, next-PC, window pointer, condition codes, identifier, state field and trap level on registered outputs, one cycle after the request.

Top module: `trap_level_stack`

## Requirements
- R1: After reset the trap level is 0 and every output (PC, next-PC, window pointer, condition codes, identifier, state field, trap type, valid and both error flags) is 0.
- R2: A trap request while the level is below MAX_TL-1 saves the state at the slot of the current level, raises the level by one and pulses outValid in the cycle after the request.
- R3: On an accepted trap the state output is 0x015 (bit 0 alternate globals, bit 2 privileged, bit 4 floating point enabled), with bit 5 (red) added only under R6. The condition-code and identifier outputs take the present input values.
- R4: On an accepted trap the window output, modulo NWIN, is: cwp-1 for type 0x024; cwp-cansave-2 when type bits [8:6] are 3'b010; cwp+1 when type bits [8:6] are 3'b011; otherwise cwp.
- R5: On an accepted trap the PC output is {trapBase[63:15], level>1 before the trap, trapType, 5'b00000} and the next-PC output is that value plus 4.
- R6: A trap accepted at level MAX_TL-1 sets the level to MAX_TL and sets state bit 5 (red).
- R7: A trap request at level MAX_TL pulses trapErr one cycle later and changes neither the level nor any other output.
- R8: A done return at a level above 0 lowers the level by one, reads that slot, and outputs PC equal to the saved next-PC and next-PC equal to the saved next-PC plus 4.
- R9: A retry return at a level above 0 lowers the level by one and outputs the saved PC and saved next-PC unchanged.
- R10: Either return restores the condition codes (saved bits [39:32]), the identifier ([31:24]), the state field ([19:8], masked with 0xF3F) and the window pointer ([7:0], low log2(NWIN) bits), and it outputs the trap type saved with that slot.
- R11: A return request at level 0 pulses retErr one cycle later and changes neither the level nor any other output.
- R12: When requests coincide, a trap takes precedence over any return, and a done takes precedence over a retry. The losing request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 1 | Trap entry request |
| trapType | input | 9 | Trap type of the request |
| doneReq | input | 1 | Return resuming after the trapped instruction |
| retryReq | input | 1 | Return re-executing the trapped instruction |
| pcIn | input | PC_W | Current PC |
| npcIn | input | PC_W | Current next-PC |
| trapBase | input | PC_W | Trap base; low 15 bits unused |
| ccIn | input | 8 | Current condition codes |
| asiIn | input | 8 | Current address-space identifier |
| pstateIn | input | 12 | Current processor-state field |
| cwpIn | input | log2(NWIN) | Current window pointer |
| canSaveIn | input | log2(NWIN) | Windows that can be saved |
| pcOut | output | PC_W | Resulting PC |
| npcOut | output | PC_W | Resulting next-PC |
| cwpOut | output | log2(NWIN) | Resulting window pointer |
| ccOut | output | 8 | Resulting condition codes |
| asiOut | output | 8 | Resulting identifier |
| pstateOut | output | 12 | Resulting processor-state field |
| typeOut | output | 9 | Trap type of the last entry or of the slot returned from |
| tlOut | output | log2(MAX_TL+1) | Current trap level |
| outValid | output | 1 | Outputs updated by an accepted trap or return |
| trapErr | output | 1 | Trap refused at maximum level |
| retErr | output | 1 | Return refused at level 0 |

## Verification
Trap entry and return unwinding can both be requested in the same cycle. A done and a retry can also arrive together. The bench raises such collisions at a mid level, at the full level (where the winning trap must be refused and the return must still do nothing), and at random points in the stimulus. It judges each collision against a model in which only the higher-precedence request acts: it compares the level, the error flags and every restored field against the model, and confirms that the slot the losing return would have popped still returns its own contents later.

// File: rtl/trap_stack_pkg.sv
package trap_stack_pkg;
  localparam int TT_W   = 9;
  localparam int CC_W   = 8;
  localparam int ASI_W  = 8;
  localparam int PST_W  = 12;
  localparam int SAVE_W = 40;

  // saved word field positions (unpacked again on return)
  localparam int SV_CC_LO  = 32;
  localparam int SV_ASI_LO = 24;
  localparam int SV_PST_LO = 8;

  localparam logic [PST_W-1:0] PST_KEEP = 12'hF3F;
  localparam logic [PST_W-1:0] PST_AG   = 12'h001;
  localparam logic [PST_W-1:0] PST_PRIV = 12'h004;
  localparam logic [PST_W-1:0] PST_FPEN = 12'h010;
  localparam logic [PST_W-1:0] PST_RED  = 12'h020;

  localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
  localparam logic [2:0]      CLS_SPILL    = 3'b010;
  localparam logic [2:0]      CLS_FILL     = 3'b011;

  typedef struct packed {
    logic push;       // accepted trap entry
    logic pop;        // accepted return
    logic popDone;    // return flavour: 1 done, 0 retry
    logic enterRed;   // entry saturates the level
    logic levelHigh;  // level above 1 before entry
  } strobe_t;
endpackage

// File: rtl/tls_ctrl.sv
module tls_ctrl
  import trap_stack_pkg::*;
#(
  parameter int MAX_TL = 5,
  localparam int TL_W  = $clog2(MAX_TL + 1),
  localparam int IDX_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapReq,
  input  logic             doneReq,
  input  logic             retryReq,
  output strobe_t          strb,
  output logic [IDX_W-1:0] slotIdx,
  output logic [TL_W-1:0]  tlOut,
  output logic             outValid,
  output logic             trapErr,
  output logic             retErr
);
  localparam logic [TL_W-1:0] LVL_MAX = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] LVL_SAT = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] LVL_ONE = TL_W'(1);

  logic [TL_W-1:0] level;
  logic atMax, atZero, anyRet;

  assign atMax  = (level == LVL_MAX);
  assign atZero = (level == '0);
  assign anyRet = doneReq | retryReq;

  always_comb begin
    strb.push      = trapReq && !atMax;
    strb.pop       = !trapReq && anyRet && !atZero;
    strb.popDone   = doneReq;
    strb.enterRed  = (level >= LVL_SAT);
    strb.levelHigh = (level > LVL_ONE);
  end

  always_comb begin
    if (strb.pop) slotIdx = IDX_W'(level - LVL_ONE);
    else          slotIdx = IDX_W'(level);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level    <= '0;
      outValid <= 1'b0;
      trapErr  <= 1'b0;
      retErr   <= 1'b0;
    end else begin
      if (strb.push)     level <= strb.enterRed ? LVL_MAX : level + LVL_ONE;
      else if (strb.pop) level <= level - LVL_ONE;
      outValid <= strb.push | strb.pop;
      trapErr  <= trapReq && atMax;
      retErr   <= !trapReq && anyRet && atZero;
    end
  end

  assign tlOut = level;
endmodule

// File: rtl/tls_datapath.sv
module tls_datapath
  import trap_stack_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int MAX_TL = 5,
  parameter int PC_W   = 64,
  localparam int WIN_W = $clog2(NWIN),
  localparam int IDX_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] slotIdx,
  input  logic [TT_W-1:0]  trapType,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [PC_W-1:0]  npcIn,
  input  logic [PC_W-1:0]  trapBase,
  input  logic [CC_W-1:0]  ccIn,
  input  logic [ASI_W-1:0] asiIn,
  input  logic [PST_W-1:0] pstateIn,
  input  logic [WIN_W-1:0] cwpIn,
  input  logic [WIN_W-1:0] canSaveIn,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  npcOut,
  output logic [WIN_W-1:0] cwpOut,
  output logic [CC_W-1:0]  ccOut,
  output logic [ASI_W-1:0] asiOut,
  output logic [PST_W-1:0] pstateOut,
  output logic [TT_W-1:0]  typeOut
);
  // slot layout: {type, nextPc, pc, savedWord}
  localparam int ENT_W  = SAVE_W + 2 * PC_W + TT_W;
  localparam int PC_LO  = SAVE_W;
  localparam int NPC_LO = SAVE_W + PC_W;
  localparam int TT_LO  = SAVE_W + 2 * PC_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [SAVE_W-1:0] packWord;
  logic [ENT_W-1:0]  newEntry;
  logic [ENT_W-1:0]  slotBus [MAX_TL];
  logic [ENT_W-1:0]  rdEntry;
  logic [SAVE_W-1:0] rdWord;
  logic [PC_W-1:0]   rdPc, rdNpc, vecAddr;
  logic [TT_W-1:0]   rdType;
  logic [WIN_W-1:0]  winNext;
  logic [PST_W-1:0]  entryPst;
  logic              unusedBits;

  // packing of the saved word
  assign packWord = {ccIn, asiIn, 4'b0000, pstateIn & PST_KEEP, 8'(cwpIn)};
  assign newEntry = {trapType, npcIn, pcIn, packWord};

  // one register per trap level
  for (genvar s = 0; s < MAX_TL; s++) begin : g_slot
    logic [ENT_W-1:0] entReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entReg <= '0;
      else if (strb.push && slotIdx == IDX_W'(s)) entReg <= newEntry;
    end
    assign slotBus[s] = entReg;
  end

  assign rdEntry = slotBus[slotIdx];
  assign rdWord  = rdEntry[SAVE_W-1:0];
  assign rdPc    = rdEntry[PC_LO +: PC_W];
  assign rdNpc   = rdEntry[NPC_LO +: PC_W];
  assign rdType  = rdEntry[TT_LO +: TT_W];

  // window pointer adjustment by trap class
  always_comb begin
    if (trapType == TT_CLEAN_WIN)
      winNext = cwpIn - WIN_W'(1);
    else if (trapType[8:6] == CLS_SPILL)
      winNext = cwpIn - canSaveIn - WIN_W'(2);
    else if (trapType[8:6] == CLS_FILL)
      winNext = cwpIn + WIN_W'(1);
    else
      winNext = cwpIn;
  end

  assign vecAddr  = {trapBase[PC_W-1:15], strb.levelHigh, trapType, 5'b00000};
  assign entryPst = PST_FPEN | PST_PRIV | PST_AG | (strb.enterRed ? PST_RED : '0);

  assign unusedBits = ^{trapBase[14:0], rdWord[23:20], rdWord[7:WIN_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcOut     <= '0;
      npcOut    <= '0;
      cwpOut    <= '0;
      ccOut     <= '0;
      asiOut    <= '0;
      pstateOut <= '0;
      typeOut   <= '0;
    end else if (strb.push) begin
      pcOut     <= vecAddr;
      npcOut    <= vecAddr + STEP;
      cwpOut    <= winNext;
      ccOut     <= ccIn;
      asiOut    <= asiIn;
      pstateOut <= entryPst;
      typeOut   <= trapType;
    end else if (strb.pop) begin
      pcOut     <= strb.popDone ? rdNpc : rdPc;
      npcOut    <= strb.popDone ? rdNpc + STEP : rdNpc;
      cwpOut    <= rdWord[WIN_W-1:0];
      ccOut     <= rdWord[SV_CC_LO +: CC_W];
      asiOut    <= rdWord[SV_ASI_LO +: ASI_W];
      pstateOut <= rdWord[SV_PST_LO +: PST_W] & PST_KEEP;
      typeOut   <= rdType;
    end
  end
endmodule

// File: rtl/trap_level_stack.sv
module trap_level_stack
  import trap_stack_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int MAX_TL = 5,
  parameter int PC_W   = 64,
  localparam int WIN_W = $clog2(NWIN),
  localparam int TL_W  = $clog2(MAX_TL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapReq,
  input  logic [8:0]       trapType,
  input  logic             doneReq,
  input  logic             retryReq,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [PC_W-1:0]  npcIn,
  input  logic [PC_W-1:0]  trapBase,
  input  logic [7:0]       ccIn,
  input  logic [7:0]       asiIn,
  input  logic [11:0]      pstateIn,
  input  logic [WIN_W-1:0] cwpIn,
  input  logic [WIN_W-1:0] canSaveIn,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  npcOut,
  output logic [WIN_W-1:0] cwpOut,
  output logic [7:0]       ccOut,
  output logic [7:0]       asiOut,
  output logic [11:0]      pstateOut,
  output logic [8:0]       typeOut,
  output logic [TL_W-1:0]  tlOut,
  output logic             outValid,
  output logic             trapErr,
  output logic             retErr
);
  localparam int IDX_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;

  strobe_t          strb;
  logic [IDX_W-1:0] slotIdx;

  tls_ctrl #(.MAX_TL(MAX_TL)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .trapReq(trapReq), .doneReq(doneReq), .retryReq(retryReq),
    .strb(strb), .slotIdx(slotIdx), .tlOut(tlOut),
    .outValid(outValid), .trapErr(trapErr), .retErr(retErr)
  );

  tls_datapath #(.NWIN(NWIN), .MAX_TL(MAX_TL), .PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .slotIdx(slotIdx),
    .trapType(trapType), .pcIn(pcIn), .npcIn(npcIn), .trapBase(trapBase),
    .ccIn(ccIn), .asiIn(asiIn), .pstateIn(pstateIn),
    .cwpIn(cwpIn), .canSaveIn(canSaveIn),
    .pcOut(pcOut), .npcOut(npcOut), .cwpOut(cwpOut), .ccOut(ccOut),
    .asiOut(asiOut), .pstateOut(pstateOut), .typeOut(typeOut)
  );
endmodule

// File: rtl/tls_checker.sv
module tls_checker #(
  parameter int NWIN   = 8,
  parameter int MAX_TL = 5,
  parameter int PC_W   = 64,
  localparam int TL_W  = $clog2(MAX_TL + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapReq,
  input logic            doneReq,
  input logic            retryReq,
  input logic [PC_W-1:0] pcOut,
  input logic [PC_W-1:0] npcOut,
  input logic [11:0]     pstateOut,
  input logic [TL_W-1:0] tlOut,
  input logic            outValid,
  input logic            trapErr,
  input logic            retErr
);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    tlOut <= TL_W'(MAX_TL));

  p_level_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && tlOut < TL_W'(MAX_TL - 1)) |=> (tlOut == $past(tlOut) + 1'b1) && outValid);

  p_priv_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && tlOut < TL_W'(MAX_TL)) |=> ((pstateOut & 12'h015) == 12'h015));

  p_vector_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && tlOut < TL_W'(MAX_TL)) |=> (npcOut == pcOut + PC_W'(4)));

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && tlOut == TL_W'(MAX_TL - 1)) |=> (tlOut == TL_W'(MAX_TL)) && pstateOut[5]);

  p_full_refuse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && tlOut == TL_W'(MAX_TL)) |=> trapErr && !outValid && $stable(pcOut) && $stable(tlOut));

  p_pop_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!trapReq && (doneReq || retryReq) && tlOut != '0) |=> (tlOut == $past(tlOut) - 1'b1));

  p_empty_refuse_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!trapReq && (doneReq || retryReq) && tlOut == '0) |=> retErr && $stable(tlOut) && $stable(npcOut));
endmodule

bind trap_level_stack tls_checker #(.NWIN(NWIN), .MAX_TL(MAX_TL), .PC_W(PC_W)) u_tls_checker (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .doneReq(doneReq), .retryReq(retryReq),
  .pcOut(pcOut), .npcOut(npcOut), .pstateOut(pstateOut), .tlOut(tlOut),
  .outValid(outValid), .trapErr(trapErr), .retErr(retErr)
);

// File: tb/trap_level_stack_bench.sv
module trap_level_stack_bench;
  localparam int NWIN   = 8;
  localparam int MAX_TL = 5;
  localparam int PC_W   = 64;
  localparam int WIN_W  = $clog2(NWIN);
  localparam int TL_W   = $clog2(MAX_TL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapReq = 0, doneReq = 0, retryReq = 0;
  logic [8:0] trapType = '0;
  logic [PC_W-1:0] pcIn = '0, npcIn = '0, trapBase = '0;
  logic [7:0] ccIn = '0, asiIn = '0;
  logic [11:0] pstateIn = '0;
  logic [WIN_W-1:0] cwpIn = '0, canSaveIn = '0;
  logic [PC_W-1:0] pcOut, npcOut;
  logic [WIN_W-1:0] cwpOut;
  logic [7:0] ccOut, asiOut;
  logic [11:0] pstateOut;
  logic [8:0] typeOut;
  logic [TL_W-1:0] tlOut;
  logic outValid, trapErr, retErr;

  always #10 clk = ~clk;  // 50 MHz

  trap_level_stack #(.NWIN(NWIN), .MAX_TL(MAX_TL), .PC_W(PC_W)) u_trap_level_stack (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
    .doneReq(doneReq), .retryReq(retryReq), .pcIn(pcIn), .npcIn(npcIn),
    .trapBase(trapBase), .ccIn(ccIn), .asiIn(asiIn), .pstateIn(pstateIn),
    .cwpIn(cwpIn), .canSaveIn(canSaveIn), .pcOut(pcOut), .npcOut(npcOut),
    .cwpOut(cwpOut), .ccOut(ccOut), .asiOut(asiOut), .pstateOut(pstateOut),
    .typeOut(typeOut), .tlOut(tlOut), .outValid(outValid), .trapErr(trapErr),
    .retErr(retErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference model state
  int mTl = 0;
  logic [39:0]     mWord [MAX_TL];
  logic [PC_W-1:0] mPc   [MAX_TL];
  logic [PC_W-1:0] mNpc  [MAX_TL];
  logic [8:0]      mType [MAX_TL];
  logic [PC_W-1:0] ePc = '0, eNpc = '0;
  logic [WIN_W-1:0] eCwp = '0;
  logic [7:0] eCc = '0, eAsi = '0;
  logic [11:0] ePst = '0;
  logic [8:0] eType = '0;
  logic eValid = 0, eTrapErr = 0, eRetErr = 0;

  task automatic check(input string tag, input string what, input logic [PC_W-1:0] act,
                       input logic [PC_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [WIN_W-1:0] expWin(input logic [8:0] tt, input logic [WIN_W-1:0] cwp,
                                              input logic [WIN_W-1:0] cs);
    if (tt == 9'h024)             return cwp - 1;        // R4 clean window
    else if (tt[8:6] == 3'b010)   return cwp - cs - 2;   // R4 spill
    else if (tt[8:6] == 3'b011)   return cwp + 1;        // R4 fill
    else                          return cwp;
  endfunction

  task automatic checkAll(input string tag);
    check(tag, "pc", pcOut, ePc);
    check(tag, "npc", npcOut, eNpc);
    check(tag, "cwp", PC_W'(cwpOut), PC_W'(eCwp));
    check(tag, "cc", PC_W'(ccOut), PC_W'(eCc));
    check(tag, "asi", PC_W'(asiOut), PC_W'(eAsi));
    check(tag, "pstate", PC_W'(pstateOut), PC_W'(ePst));
    check(tag, "type", PC_W'(typeOut), PC_W'(eType));
    check(tag, "level", PC_W'(tlOut), PC_W'(mTl));
    check(tag, "valid", PC_W'(outValid), PC_W'(eValid));
    check(tag, "trapErr", PC_W'(trapErr), PC_W'(eTrapErr));
    check(tag, "retErr", PC_W'(retErr), PC_W'(eRetErr));
  endtask

  task automatic randomInputs();
    int k = $urandom % 4;
    pcIn      = {$urandom, $urandom};
    npcIn     = {$urandom, $urandom};
    trapBase  = {$urandom, $urandom};
    ccIn      = 8'($urandom);
    asiIn     = 8'($urandom);
    pstateIn  = 12'($urandom);
    cwpIn     = WIN_W'($urandom);
    canSaveIn = WIN_W'($urandom);
    case (k)
      0: trapType = 9'h024;
      1: trapType = {3'b010, 6'($urandom)};
      2: trapType = {3'b011, 6'($urandom)};
      default: trapType = 9'($urandom);
    endcase
  endtask

  // apply one request cycle, update model, compare one cycle later
  task automatic runOp(input bit tr, input bit dn, input bit rt, input string tag);
    @(negedge clk);
    trapReq = tr; doneReq = dn; retryReq = rt;
    eValid = 0; eTrapErr = 0; eRetErr = 0;
    if (tr) begin
      if (mTl == MAX_TL) eTrapErr = 1;  // R7 and R12: return ignored
      else begin
        mWord[mTl] = {ccIn, asiIn, 4'b0000, pstateIn & 12'hF3F, 8'(cwpIn)};
        mPc[mTl] = pcIn; mNpc[mTl] = npcIn; mType[mTl] = trapType;
        ePc  = {trapBase[PC_W-1:15], (mTl > 1) ? 1'b1 : 1'b0, trapType, 5'b00000};
        eNpc = ePc + 4;
        eCwp = expWin(trapType, cwpIn, canSaveIn);
        eCc = ccIn; eAsi = asiIn; eType = trapType;
        ePst = 12'h015 | ((mTl >= MAX_TL - 1) ? 12'h020 : 12'h000);
        mTl = (mTl >= MAX_TL - 1) ? MAX_TL : mTl + 1;
        eValid = 1;
      end
    end else if (dn || rt) begin
      if (mTl == 0) eRetErr = 1;
      else begin
        mTl--;
        if (dn) begin ePc = mNpc[mTl]; eNpc = mNpc[mTl] + 4; end
        else    begin ePc = mPc[mTl];  eNpc = mNpc[mTl];     end
        eCc  = mWord[mTl][39:32];
        eAsi = mWord[mTl][31:24];
        ePst = mWord[mTl][19:8] & 12'hF3F;
        eCwp = mWord[mTl][WIN_W-1:0];
        eType = mType[mTl];
        eValid = 1;
      end
    end
    @(negedge clk);
    trapReq = 0; doneReq = 0; retryReq = 0;
    checkAll(tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    randomInputs();
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // fill the stack: entries R2 R3 R4 R5, last one saturates (R6)
    for (int i = 0; i < MAX_TL; i++) begin
      randomInputs();
      runOp(1, 0, 0, (i == MAX_TL - 1) ? "R6" : "R5");
    end
    randomInputs(); runOp(1, 0, 0, "R7");
    randomInputs(); runOp(1, 1, 0, "R12");   // trap at full level beats done
    randomInputs(); runOp(0, 1, 1, "R12");   // done beats retry
    randomInputs(); runOp(0, 0, 1, "R9");
    randomInputs(); runOp(1, 0, 1, "R12");   // trap beats retry mid level
    randomInputs(); runOp(0, 1, 0, "R8");
    for (int i = 0; i < MAX_TL; i++) begin
      randomInputs(); runOp(0, 0, 1, "R10");
    end
    randomInputs(); runOp(0, 1, 0, "R11");
    randomInputs(); runOp(0, 0, 1, "R11");

    // window classes directed: R4
    randomInputs(); trapType = 9'h024; runOp(1, 0, 0, "R4");
    randomInputs(); trapType = 9'h085; runOp(1, 0, 0, "R4");
    randomInputs(); trapType = 9'h0C3; runOp(1, 0, 0, "R4");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom % 16;
      randomInputs();
      if (sel < 7)       runOp(1, 0, 0, "R2");
      else if (sel < 10) runOp(0, 1, 0, "R8");
      else if (sel < 13) runOp(0, 0, 1, "R9");
      else if (sel < 14) runOp(1, 1, 1, "R12");
      else if (sel < 15) runOp(0, 1, 1, "R12");
      else               runOp(1, 0, 0, "R4");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule